// File: doc/BRIEF.md
# Non-Linear Ratio External Clock Divider

This block produces an external clock for audio-style peripherals by dividing a fixed 96 MHz base clock. Software holds a 16-bit control word. A 6-bit ratio code inside that word selects the divisor. The code table is non-linear. Small codes step the divisor by one. Larger codes step it by two, so odd divisors above 8 cannot be encoded. The block decodes the code, runs a period counter that gives a near-50% duty cycle, and shows the divisor that is currently in force.

Bit 0 of the control word picks the count source. When it is clear, the counter advances on every base-clock cycle. When it is set, the counter advances only on cycles where the alternate-source enable is high. A ratio change never cuts a period short. The new divisor is taken at the point where the running period wraps.

Two write strobes are provided. A full write loads the whole control word. A ratio write changes only the ratio field and leaves every other bit as it was.

Top module: `extclk_ratio_div`

## Requirements
- R1: Ratio codes 0 to 6 decode to divisor = code + 2, which covers divisors 2 through 8.
- R2: Ratio codes from 7 upward decode to divisor = 2 × (code − 6) + 8, which is always even. Code 50 gives 96.
- R3: Codes 51 to 63 would give a divisor above 96, so they saturate to 96. The divisor in force is always between 2 and 96.
- R4: While reset is held, `ctrl_q` reads 0 and `div_active` reads 2 (code 0, base source), and `clk_out` is low.
- R5: The ratio code is bits [7:2] of the control word. `ratio_wr` replaces only those bits with the same bits of `wr_data`, and all other bits keep their value. `ctrl_wr` loads all 16 bits. If both strobes are high, `ctrl_wr` wins.
- R6: A new divisor takes effect only when the running output period ends. Until then the old divisor stays in force and stays visible on `div_active`.
- R7: Each output period lasts D source ticks, where D is the divisor. `clk_out` is high for the first floor(D/2) ticks and low for the remaining D − floor(D/2) ticks. For odd D the low phase is one tick longer.
- R8: When control bit 0 is 0, every clock cycle is a source tick. When it is 1, only cycles with `alt_tick` high are ticks, and with no tick the output and the divisor in force do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 96 MHz base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Load the whole control word from `wr_data` |
| ratio_wr | input | 1 | Load only the ratio field from `wr_data[7:2]` |
| wr_data | input | 16 | Write data |
| alt_tick | input | 1 | Count enable from the alternate source, used when control bit 0 is 1 |
| clk_out | output | 1 | Divided output clock |
| div_active | output | 7 | Divisor of the period now running |
| ctrl_q | output | 16 | Current control word |

## Verification
A ratio write and the end of a period can fall in the same cycle. The write then affects only the period after the next one, because the wrap in that cycle loads the divisor from the old control word. The bench writes each of the 64 codes at an arbitrary point in a period. It then measures only from the next rising edge after the write, so the boundary collision is tolerated there. In a separate case, a large divisor is replaced in the middle of its high phase. That case checks that the interrupted period still runs to its full old length, and that the very next period uses the new divisor.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

   typedef enum logic {
      SRC_BASE = 1'b0,
      SRC_ALT  = 1'b1
   } src_sel_e;

   // Two-segment code: unit steps up to fine_last, then steps of two.
   function automatic int unsigned ratio_raw_div(
      input int unsigned code,
      input int unsigned fine_last,
      input int unsigned div_min
   );
      if (code <= fine_last)
         return code + div_min;
      else
         return (code - fine_last) * 2 + fine_last + div_min;
   endfunction

endpackage

// File: rtl/extclk_ratio_decode.sv
module extclk_ratio_decode #(
   parameter int unsigned SEL_W     = 6,
   parameter int unsigned DIV_W     = 7,
   parameter int unsigned FINE_LAST = 6,
   parameter int unsigned DIV_MIN   = 2,
   parameter int unsigned DIV_MAX   = 96
) (
   input  logic [SEL_W-1:0] code_i,
   output logic [DIV_W-1:0] div_o
);
   import extclk_pkg::*;

   localparam int unsigned CODE_TOP = (1 << SEL_W) - 1;
   localparam int unsigned RAW_TOP  = ratio_raw_div(CODE_TOP, FINE_LAST, DIV_MIN);

   if (DIV_MAX >= (1 << DIV_W)) begin : g_chk_w
      $error("DIV_MAX does not fit in DIV_W bits");
   end
   if (DIV_MIN < 2) begin : g_chk_min
      $error("DIV_MIN must be at least 2");
   end

   int unsigned raw;

   always_comb begin
      raw = ratio_raw_div(32'(code_i), FINE_LAST, DIV_MIN);
   end

   if (RAW_TOP > DIV_MAX) begin : g_sat
      always_comb begin
         if (raw > DIV_MAX)
            div_o = DIV_W'(DIV_MAX);
         else
            div_o = DIV_W'(raw);
      end
   end else begin : g_direct
      always_comb begin
         div_o = DIV_W'(raw);
      end
   end

endmodule

// File: rtl/extclk_tick_select.sv
module extclk_tick_select #(
   parameter bit HAS_ALT = 1'b1
) (
   input  extclk_pkg::src_sel_e src_i,
   input  logic                 alt_tick_i,
   output logic                 tick_o
);
   import extclk_pkg::*;

   if (HAS_ALT) begin : g_alt
      always_comb begin
         tick_o = (src_i == SRC_ALT) ? alt_tick_i : 1'b1;
      end
   end else begin : g_base_only
      always_comb begin
         tick_o = 1'b1;
      end
   end

endmodule

// File: rtl/extclk_phase_counter.sv
module extclk_phase_counter #(
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned RST_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [DIV_W-1:0] div_next_i,
   output logic             out_o,
   output logic [DIV_W-1:0] div_act_o
);
   localparam logic [DIV_W-1:0] RST_D   = DIV_W'(RST_DIV);
   localparam logic [DIV_W-1:0] RST_CNT = DIV_W'(RST_DIV - 1);

   if (RST_DIV < 2) begin : g_chk_rst
      $error("RST_DIV must be at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic             out_q;
   logic             at_end;
   logic [DIV_W-1:0] nxt_cnt;
   logic [DIV_W-1:0] nxt_div;

   always_comb begin
      at_end  = (cnt_q == div_q - 1'b1);
      nxt_div = at_end ? div_next_i : div_q;
      nxt_cnt = at_end ? '0 : cnt_q + 1'b1;
   end

   // Reset parks the counter on the last low tick of a period,
   // so the first tick starts a fresh period with the pending divisor.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= RST_CNT;
         div_q <= RST_D;
         out_q <= 1'b0;
      end else if (tick_i) begin
         cnt_q <= nxt_cnt;
         div_q <= nxt_div;
         out_q <= (nxt_cnt < (nxt_div >> 1));
      end
   end

   assign out_o     = out_q;
   assign div_act_o = div_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < div_q);                                             // R7
   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && at_end) |=> $stable(div_q));                    // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ($stable(out_q) && $stable(cnt_q)));            // R8

endmodule

// File: rtl/extclk_ratio_div.sv
module extclk_ratio_div #(
   parameter int unsigned CTRL_W    = 16,
   parameter int unsigned SEL_LSB   = 2,
   parameter int unsigned SEL_W     = 6,
   parameter int unsigned DIV_W     = 7,
   parameter int unsigned FINE_LAST = 6,
   parameter int unsigned DIV_MIN   = 2,
   parameter int unsigned DIV_MAX   = 96,
   parameter bit          HAS_ALT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              ratio_wr,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              alt_tick,
   output logic              clk_out,
   output logic [DIV_W-1:0]  div_active,
   output logic [CTRL_W-1:0] ctrl_q
);
   import extclk_pkg::*;

   localparam int unsigned SEL_MSB = SEL_LSB + SEL_W - 1;
   localparam logic [CTRL_W-1:0] SEL_MASK =
      CTRL_W'(((1 << SEL_W) - 1) << SEL_LSB);

   if (SEL_MSB >= CTRL_W) begin : g_chk_field
      $error("ratio field exceeds control word");
   end
   if (SEL_LSB == 0) begin : g_chk_src
      $error("ratio field overlaps source bit");
   end

   logic [CTRL_W-1:0] ctrl_r;
   logic [SEL_W-1:0]  code;
   logic [DIV_W-1:0]  div_next;
   logic              tick;
   src_sel_e          src;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_r <= '0;
      else if (ctrl_wr)
         ctrl_r <= wr_data;
      else if (ratio_wr)
         ctrl_r <= (ctrl_r & ~SEL_MASK) | (wr_data & SEL_MASK);
   end

   assign code = ctrl_r[SEL_MSB:SEL_LSB];
   assign src  = src_sel_e'(ctrl_r[0]);

   extclk_ratio_decode #(
      .SEL_W(SEL_W), .DIV_W(DIV_W), .FINE_LAST(FINE_LAST),
      .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
   ) u_decode (
      .code_i(code),
      .div_o (div_next)
   );

   extclk_tick_select #(.HAS_ALT(HAS_ALT)) u_tick (
      .src_i     (src),
      .alt_tick_i(alt_tick),
      .tick_o    (tick)
   );

   extclk_phase_counter #(.DIV_W(DIV_W), .RST_DIV(DIV_MIN)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .div_next_i(div_next),
      .out_o     (clk_out),
      .div_act_o (div_active)
   );

   assign ctrl_q = ctrl_r;

   AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (div_next >= DIV_W'(DIV_MIN)) && (div_next <= DIV_W'(DIV_MAX))
      && (div_active >= DIV_W'(DIV_MIN)) && (div_active <= DIV_W'(DIV_MAX))); // R3
   AST_UPPER_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (code > SEL_W'(FINE_LAST)) |-> !div_next[0]);               // R2
   AST_FINE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (code <= SEL_W'(FINE_LAST)) |-> (div_next <= DIV_W'(FINE_LAST + DIV_MIN))); // R1
   AST_RATIO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_wr && !ctrl_wr) |=> ((ctrl_r & ~SEL_MASK) == $past(ctrl_r & ~SEL_MASK))); // R5

endmodule

// File: tb/extclk_ratio_div_test.sv
module extclk_ratio_div_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic        ratio_wr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        alt_tick = 1'b0;
   logic        clk_out;
   logic [6:0]  div_active;
   logic [15:0] ctrl_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit alt_run = 1'b0;
   int altc = 0;

   extclk_ratio_div uut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ratio_wr(ratio_wr),
      .wr_data(wr_data), .alt_tick(alt_tick), .clk_out(clk_out),
      .div_active(div_active), .ctrl_q(ctrl_q)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (alt_run) begin
         alt_tick <= (altc == 2);
         altc     <= (altc == 2) ? 0 : altc + 1;
      end else begin
         alt_tick <= 1'b0;
         altc     <= 0;
      end
   end

   function automatic int exp_div(input int code);
      int d;
      if (code <= 6) d = code + 2;
      else d = (code - 6) * 2 + 8;
      if (d > 96) d = 96;
      return d;
   endfunction

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic do_write(input bit full, input logic [15:0] d);
      ctrl_wr  = full;
      ratio_wr = !full;
      wr_data  = d;
      @(negedge clk);
      ctrl_wr  = 1'b0;
      ratio_wr = 1'b0;
   endtask

   task automatic sync_rise();
      logic prev;
      prev = clk_out;
      @(negedge clk);
      while (!(clk_out && !prev)) begin
         prev = clk_out;
         @(negedge clk);
      end
   endtask

   // Caller stands on a high sample already counted in hi0.
   task automatic measure(input int hi0, output int hi, output int lo);
      hi = hi0;
      @(negedge clk);
      while (clk_out) begin hi++; @(negedge clk); end
      lo = 1;
      @(negedge clk);
      while (!clk_out) begin lo++; @(negedge clk); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi, lo, d;
      logic [15:0] expc;
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4 ctrl", int'(ctrl_q), 0);
      check("R4 div", int'(div_active), 2);
      check("R4 out", int'(clk_out), 0);
      rst_n = 1'b1;

      // R5 partial write keeps other bits
      do_write(1'b1, 16'hA501);
      check("R5 full", int'(ctrl_q), 16'hA501);
      expc = (16'hA501 & ~16'h00FC) | (16'h5AFE & 16'h00FC);
      do_write(1'b0, 16'h5AFE);
      check("R5 ratio", int'(ctrl_q), int'(expc));
      ctrl_wr = 1'b1; ratio_wr = 1'b1; wr_data = 16'h0000;
      @(negedge clk);
      ctrl_wr = 1'b0; ratio_wr = 1'b0;
      check("R5 priority", int'(ctrl_q), 0);

      // R1 R2 R3 R7 sweep over every code
      for (int c = 0; c < 64; c++) begin
         do_write(1'b0, 16'(c << 2));
         sync_rise();
         d = exp_div(c);
         check(c <= 6 ? "R1 div" : (c <= 50 ? "R2 div" : "R3 div"), int'(div_active), d);
         measure(1, hi, lo);
         check("R7 high", hi, d / 2);
         check("R7 low", lo, d - d / 2);
      end

      // R6 mid-period change
      do_write(1'b0, 16'(50 << 2));
      sync_rise();
      repeat (3) @(negedge clk);
      check("R6 still high", int'(clk_out), 1);
      do_write(1'b0, 16'h0000);
      check("R6 old div", int'(div_active), 96);
      measure(5, hi, lo);
      check("R6 old high", hi, 48);
      check("R6 old low", lo, 48);
      check("R6 new div", int'(div_active), 2);
      measure(1, hi, lo);
      check("R6 new high", hi, 1);
      check("R6 new low", lo, 1);

      // R8 alternate source, frozen without ticks
      do_write(1'b1, 16'h000D);   // code 3 -> divisor 5, source bit set
      repeat (2) @(negedge clk);
      begin
         logic o0; logic [6:0] d0;
         o0 = clk_out; d0 = div_active;
         repeat (40) @(negedge clk);
         check("R8 frozen out", int'(clk_out), int'(o0));
         check("R8 frozen div", int'(div_active), int'(d0));
      end
      alt_run = 1'b1;
      sync_rise();
      sync_rise();
      check("R8 alt div", int'(div_active), 5);
      measure(1, hi, lo);
      check("R8 alt high", hi, 2 * 3);
      check("R8 alt low", lo, 3 * 3);
      alt_run = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule